// File: doc/BRIEF.md
# Stored-Address 3-to-8 Line Decoder

This block turns a 3-bit binary address into an 8-bit active-high one-hot select vector. An address-hold stage sits in front of the decode. While the hold control is low, the stage is transparent and the outputs follow the live address. When the hold control goes high, the stage keeps the address it saw on the last clock edge before the change. From then on the address pins have no effect until the hold control falls again.

Two enables of opposite polarity gate the outputs: one is active low and the other is active high. The select vector is live only when the first is low and the second is high. Otherwise every output is low. The enables act only at the output. The hold stage keeps loading or keeping its address whatever the enables do.

Because each enable has its own polarity, several instances can be joined into a wider stored-address decoder. A first-level decoder drives the active-high enables of the second-level instances, and all instances share one hold control. The hold stage is built as a clocked register rather than a latch. Its content is cleared by an active-low reset.

Top module: `latchDecoder`

## Requirements
- R1: While `latchEnN` is 0 and the outputs are enabled, `decOut` decodes the live `addrIn` in the same cycle, with no clock edge needed.
- R2: In the first cycle with `latchEnN` at 1, the decoded address is the value `addrIn` had at the last rising clock edge where `latchEnN` was 0.
- R3: While `latchEnN` stays at 1, any change on `addrIn`, including changes between clock edges, leaves `decOut` unchanged.
- R4: Whenever `enableN` is 1 or `enable` is 0, all bits of `decOut` are 0, whatever the address or the held state.
- R5: When `enableN` is 0 and `enable` is 1, exactly one bit of `decOut` is 1.
- R6: The hold stage loads from `addrIn` on each rising clock edge with `latchEnN` at 0, even while the outputs are disabled. The address it loaded shows once the outputs are enabled with `latchEnN` at 1.
- R7: While `rstN` is 0 the held address is cleared to 0. After reset, with `latchEnN` at 1 and the outputs enabled, `decOut` is 8'h01.
- R8: `addrIn[0]` is the least significant bit. Address value n drives bit n of `decOut` high, for every n from 0 to 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the address-hold register |
| rstN | input | 1 | Active-low reset; clears the held address |
| addrIn | input | ADDR_W (3) | Binary address, bit 0 least significant |
| latchEnN | input | 1 | 0: transparent and loading; 1: hold |
| enableN | input | 1 | Active-low output enable |
| enable | input | 1 | Active-high output enable |
| decOut | output | 2**ADDR_W (8) | One-hot active-high select vector |

## Verification
The hardest case to reach from the ports is an address that was loaded while the outputs were disabled. It only becomes visible after the enables reopen, with the hold control already high. The stimulus table loads an address with the outputs gated off and raises the hold control on the next vector. It then re-enables the outputs and expects the quietly loaded value rather than the last value that was visible. Directed sequences move `addrIn` several times between clock edges, both while holding and while transparent. They also assert reset in the middle of a hold so that the cleared state is checked.

// File: rtl/latchDecoderPkg.sv
package latchDecoderPkg;

  // Strobes handed from the control module to the datapath.
  typedef struct packed {
    logic loadAddr;  // copy addrIn into the hold register on this edge
    logic passLive;  // decode the live address instead of the held one
    logic outGate;   // outputs may be driven
  } decStrobe_t;

endpackage

// File: rtl/latchDecoderCtrl.sv
module latchDecoderCtrl
  import latchDecoderPkg::*;
(
  input  logic       latchEnN,
  input  logic       enableN,
  input  logic       enable,
  output decStrobe_t strobe
);

  always_comb begin
    strobe          = '0;
    strobe.loadAddr = ~latchEnN;
    strobe.passLive = ~latchEnN;
    strobe.outGate  = ~enableN & enable;
  end

endmodule

// File: rtl/latchDecoderPath.sv
module latchDecoderPath
  import latchDecoderPkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int OUT_W = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  decStrobe_t        strobe,
  output logic [OUT_W-1:0]  decOut
);

  logic [ADDR_W-1:0] heldAddr;
  logic [ADDR_W-1:0] effAddr;

  // Address-hold register: follows the bus while transparent.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr <= '0;
    end else if (strobe.loadAddr) begin
      heldAddr <= addrIn;
    end
  end

  assign effAddr = strobe.passLive ? addrIn : heldAddr;

  // One comparator per output line.
  genvar lineIdx;
  generate
    for (lineIdx = 0; lineIdx < OUT_W; lineIdx++) begin : g_line
      assign decOut[lineIdx] = strobe.outGate &&
                               (effAddr == ADDR_W'(lineIdx));
    end
  endgenerate

endmodule

// File: rtl/latchDecoder.sv
module latchDecoder
  import latchDecoderPkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int OUT_W = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              latchEnN,
  input  logic              enableN,
  input  logic              enable,
  output logic [OUT_W-1:0]  decOut
);

  decStrobe_t strobe;

  latchDecoderCtrl u_ctrl (
    .latchEnN (latchEnN),
    .enableN  (enableN),
    .enable   (enable),
    .strobe   (strobe)
  );

  latchDecoderPath #(.ADDR_W(ADDR_W)) u_path (
    .clk    (clk),
    .rstN   (rstN),
    .addrIn (addrIn),
    .strobe (strobe),
    .decOut (decOut)
  );

endmodule

// File: rtl/latchDecoderChk.sv
module latchDecoderChk #(
  parameter int ADDR_W = 3,
  localparam int OUT_W = 1 << ADDR_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addrIn,
  input logic              latchEnN,
  input logic              enableN,
  input logic              enable,
  input logic [OUT_W-1:0]  decOut
);

  logic gateOn;
  assign gateOn = ~enableN & enable;

  assert_transparent_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!latchEnN && gateOn) |-> (decOut == (OUT_W'(1) << addrIn)));

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(latchEnN) && $past(rstN) && gateOn) |->
      (decOut == (OUT_W'(1) << $past(addrIn))));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (latchEnN && $past(latchEnN) && $past(rstN) && gateOn && $past(gateOn))
      |-> $stable(decOut));

  assert_gated_off_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!gateOn) |-> (decOut == '0));

  assert_onehot_R5: assert property (@(posedge clk) disable iff (!rstN)
    gateOn |-> ($countones(decOut) == 1));

endmodule

bind latchDecoder latchDecoderChk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .addrIn   (addrIn),
  .latchEnN (latchEnN),
  .enableN  (enableN),
  .enable   (enable),
  .decOut   (decOut)
);

// File: tb/tb_latchDecoder.sv
`timescale 1ns/1ps
module tb_latchDecoder;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] addrIn = 3'd0;
  logic       latchEnN = 1'b1;
  logic       enableN = 1'b0;
  logic       enable = 1'b1;
  logic [7:0] decOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  latchDecoder dut (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .latchEnN(latchEnN),
    .enableN(enableN), .enable(enable), .decOut(decOut)
  );

  // {req[3:0], latchEnN, enableN, enable, addr[2:0], expected[7:0]}
  localparam logic [17:0] VEC [20] = '{
    {4'd1, 3'b001, 3'd0, 8'h01},  // R1 live decode
    {4'd8, 3'b001, 3'd1, 8'h02},  // R8 bit order
    {4'd8, 3'b001, 3'd2, 8'h04},  // R8
    {4'd8, 3'b001, 3'd3, 8'h08},  // R8
    {4'd8, 3'b001, 3'd4, 8'h10},  // R8
    {4'd8, 3'b001, 3'd5, 8'h20},  // R8
    {4'd8, 3'b001, 3'd6, 8'h40},  // R8
    {4'd8, 3'b001, 3'd7, 8'h80},  // R8, loads 7
    {4'd2, 3'b101, 3'd2, 8'h80},  // R2 held 7
    {4'd3, 3'b101, 3'd5, 8'h80},  // R3 address ignored
    {4'd4, 3'b111, 3'd5, 8'h00},  // R4 enableN high
    {4'd4, 3'b100, 3'd5, 8'h00},  // R4 enable low
    {4'd4, 3'b110, 3'd0, 8'h00},  // R4 both off
    {4'd3, 3'b101, 3'd0, 8'h80},  // R3 still 7
    {4'd6, 3'b011, 3'd3, 8'h00},  // R6 loads 3 while disabled
    {4'd6, 3'b101, 3'd6, 8'h08},  // R6 shows 3
    {4'd6, 3'b000, 3'd4, 8'h00},  // R6 loads 4 while disabled
    {4'd6, 3'b101, 3'd1, 8'h10},  // R6 shows 4
    {4'd1, 3'b001, 3'd6, 8'h40},  // R1
    {4'd2, 3'b101, 3'd0, 8'h40}   // R2 held 6
  };

  task automatic check(input string req, input logic [7:0] exp);
    compared++;
    if (decOut !== exp) begin
      mismatched++;
      $display("FAIL %s: decOut=%h expected=%h at %0t", req, decOut, exp, $time);
    end
  endtask

  task automatic drive(input logic le, input logic en_n, input logic en,
                       input logic [2:0] a);
    @(negedge clk);
    latchEnN = le; enableN = en_n; enable = en; addrIn = a;
  endtask

  initial begin
    // R7: reset state with hold active
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;
    check("R7", 8'h01);

    // Vector table
    for (int i = 0; i < 20; i++) begin
      drive(VEC[i][13], VEC[i][12], VEC[i][11], VEC[i][10:8]);
      @(posedge clk); #1;
      check($sformatf("R%0d row %0d", VEC[i][17:14], i), VEC[i][7:0]);
      if (!VEC[i][12] && VEC[i][11]) begin
        compared++;
        if ($countones(decOut) != 1) begin
          mismatched++;
          $display("FAIL R5: ones=%0d expected=1 row %0d", $countones(decOut), i);
        end
      end
    end

    // R3: glitches between edges while holding
    drive(1'b0, 1'b0, 1'b1, 3'd6);
    drive(1'b1, 1'b0, 1'b1, 3'd6);
    for (int c = 0; c < 3; c++) begin
      for (int g = 0; g < 4; g++) begin
        #3 addrIn = 3'(c * 3 + g);
        #1 check("R3 glitch", 8'h40);
      end
      @(negedge clk);
    end

    // R1: transparent follows mid-cycle changes
    latchEnN = 1'b0;
    for (int a = 0; a < 8; a++) begin
      #2 addrIn = 3'(a);
      #0.5 check("R1 mid-cycle", 8'(1) << a);
    end

    // R7: reset in the middle of a hold
    drive(1'b0, 1'b0, 1'b1, 3'd5);
    drive(1'b1, 1'b0, 1'b1, 3'd2);
    @(posedge clk); #1;
    check("R2 before reset", 8'h20);
    @(negedge clk); rstN = 1'b0;
    #1 check("R7 in reset", 8'h01);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R7 after reset", 8'h01);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule